// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block maps a flat virtual address space onto physical device addresses through four programmable windows. Window 0 is a memory area, window 1 covers device registers, and windows 2 and 3 are more memory areas. Each window has a physical start address and a size, and a host loads both through a small configuration write port. In virtual space the windows sit back to back in index order: window 0 begins at virtual address 0, and each later window begins where the one before it ends. Each window can therefore point at any physical start, however large its neighbours are.

For each request the block finds the window that holds the virtual address. It returns that window's physical start plus the offset of the address inside the window. If no window holds the address, it reports a miss. The result comes out of a register one cycle after the request. A firmware loader or bus bridge can keep one fixed virtual map while the physical layout behind it moves.

Top module: `win_xlat`

## Requirements
- R1: After reset, `rspValid`, `rspHit` and `rspMiss` are low, and every window start and size is zero, so any request misses.
- R2: A request presented with `reqValid` high gives exactly one result, with `rspValid` high on the following cycle. `rspValid` is low in every cycle that follows a cycle without a request.
- R3: Window 0 covers virtual addresses 0 up to (but not including) its size. An address there translates to start0 plus the address.
- R4: The virtual base of window k is the sum of the sizes of windows 0..k-1, computed without 32-bit wraparound. An address at offset d inside window k translates to startk + d, modulo 2^32.
- R5: An address at or beyond the sum of all four sizes, or any request while every size is zero, raises `rspMiss` and drives `rspAddr` to zero.
- R6: A window of size zero never matches. An address at its virtual base falls into the next non-empty window.
- R7: When a configuration write and a request occur in the same cycle, the request is translated with the configuration in force before that write. The write affects only later requests.
- R8: A configuration write targets window `cfgSel[2:1]`. `cfgSel[0]` = 0 loads the physical start and `cfgSel[0]` = 1 loads the size. No other window field changes.
- R9: While `rspValid` is high, exactly one of `rspHit` and `rspMiss` is high. While it is low, both are low and `rspAddr` is zero.
- R10: Rewriting a size at run time shifts the virtual bases of all later windows for the very next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Window index in bits [2:1]; bit 0 selects size (1) or start (0) |
| cfgData | input | 32 | Value written to the selected field |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 32 | Virtual address to translate |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspHit | output | 1 | Address fell inside a window |
| rspMiss | output | 1 | Address fell inside no window |
| rspAddr | output | 32 | Translated physical address, zero on a miss |

## Verification
A configuration write and a translation request can land in the same clock cycle. This is the case where the old and new layouts compete. The bench drives a size write to window 0 and a request for an address that the new size moves out of window 0, both in one cycle. It expects the physical address of the old layout, then repeats the request alone and expects the address in window 2 that the new stacking gives. Assertions also relate each request to its one-cycle-later result, using the total span that is in force when the request is made.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Window count is fixed by the address map: mem, regs, mem2, mem3.
  localparam int XLAT_WINDOWS = 4;
  localparam int XLAT_IDX_W   = $clog2(XLAT_WINDOWS);
  localparam int XLAT_SEL_W   = XLAT_IDX_W + 1;

  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic [XLAT_WINDOWS-1:0] startWe;
    logic [XLAT_WINDOWS-1:0] sizeWe;
    logic                    capture;
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic                  cfgWrEn,
  input  logic [XLAT_SEL_W-1:0] cfgSel,
  input  logic                  reqValid,
  output xlatStrobe_t           strobe
);
  logic [XLAT_IDX_W-1:0] winIdx;
  logic                  pickSize;

  assign winIdx   = cfgSel[XLAT_SEL_W-1:1];
  assign pickSize = cfgSel[0];

  generate
    for (genvar w = 0; w < XLAT_WINDOWS; w++) begin : g_dec
      assign strobe.startWe[w] = cfgWrEn && !pickSize && (winIdx == XLAT_IDX_W'(w));
      assign strobe.sizeWe[w]  = cfgWrEn &&  pickSize && (winIdx == XLAT_IDX_W'(w));
    end
  endgenerate

  assign strobe.capture = reqValid;
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xlatStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W:0]   totalSpan
);
  localparam int SPAN_W = ADDR_W + 1;

  logic [ADDR_W-1:0] winStart [XLAT_WINDOWS];
  logic [ADDR_W-1:0] winSize  [XLAT_WINDOWS];
  logic [SPAN_W-1:0] winBase  [XLAT_WINDOWS+1];
  logic [ADDR_W-1:0] physCand [XLAT_WINDOWS];
  logic [XLAT_WINDOWS-1:0] winHit;
  logic [SPAN_W-1:0] reqWide;

  logic              anyHit;
  logic [ADDR_W-1:0] physSel;

  assign reqWide    = {1'b0, reqAddr};
  assign winBase[0] = '0;

  generate
    for (genvar w = 0; w < XLAT_WINDOWS; w++) begin : g_win
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          winStart[w] <= '0;
          winSize[w]  <= '0;
        end else begin
          if (strobe.startWe[w]) winStart[w] <= cfgData;
          if (strobe.sizeWe[w])  winSize[w]  <= cfgData;
        end
      end

      // Back-to-back stacking in virtual space, carried one bit wider.
      assign winBase[w+1] = winBase[w] + {1'b0, winSize[w]};

      assign winHit[w] = (winSize[w] != '0) &&
                         (reqWide >= winBase[w]) &&
                         (reqWide <  winBase[w+1]);

      assign physCand[w] = winStart[w] + (reqAddr - winBase[w][ADDR_W-1:0]);
    end
  endgenerate

  assign totalSpan = winBase[XLAT_WINDOWS];

  // Lowest index wins; scan downward so lower windows overwrite.
  always_comb begin
    anyHit  = 1'b0;
    physSel = '0;
    for (int w = XLAT_WINDOWS - 1; w >= 0; w--) begin
      if (winHit[w]) begin
        anyHit  = 1'b1;
        physSel = physCand[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspAddr  <= '0;
    end else begin
      rspValid <= strobe.capture;
      rspHit   <= strobe.capture &&  anyHit;
      rspMiss  <= strobe.capture && !anyHit;
      rspAddr  <= (strobe.capture && anyHit) ? physSel : '0;
    end
  end
endmodule

// File: rtl/win_xlat.sv
module win_xlat
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWrEn,
  input  logic [XLAT_SEL_W-1:0] cfgSel,
  input  logic [ADDR_W-1:0]     cfgData,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  rspValid,
  output logic                  rspHit,
  output logic                  rspMiss,
  output logic [ADDR_W-1:0]     rspAddr
);
  xlatStrobe_t     strobe;
  logic [ADDR_W:0] totalSpan;

  xlat_ctrl u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .reqValid(reqValid),
    .strobe  (strobe)
  );

  xlat_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .cfgData  (cfgData),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspMiss  (rspMiss),
    .rspAddr  (rspAddr),
    .totalSpan(totalSpan)
  );
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspMiss,
  input logic [ADDR_W-1:0] rspAddr,
  input logic [ADDR_W:0]   totalSpan
);
  assert_req_gives_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  assert_idle_gives_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> ($countones({rspHit, rspMiss}) == 1));

  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> (!rspHit && !rspMiss && rspAddr == '0));

  assert_miss_zero_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rspMiss |-> (rspAddr == '0));

  assert_beyond_span_misses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && ({1'b0, reqAddr} >= totalSpan)) |=> rspMiss);

  assert_inside_span_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && ({1'b0, reqAddr} < totalSpan)) |=> rspHit);
endmodule

bind win_xlat xlat_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspMiss  (rspMiss),
  .rspAddr  (rspAddr),
  .totalSpan(totalSpan)
);

// File: tb/tb_win_xlat.sv
`timescale 1ns/1ps
module tb_win_xlat;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfgWrEn;
  logic [2:0]  cfgSel;
  logic [31:0] cfgData;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic        rspValid, rspHit, rspMiss;
  logic [31:0] rspAddr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  win_xlat dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspAddr(rspAddr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Checks one registered result, sampled just after the edge that loaded it.
  task automatic expectRsp(input string req, input bit expHit, input logic [31:0] expAddr);
    check(rspValid === 1'b1, req, "rspValid", {31'b0, rspValid}, 32'h1);
    check(rspHit === expHit && rspMiss === !expHit, req, "hit/miss",
          {30'b0, rspHit, rspMiss}, {30'b0, expHit, !expHit});
    check(rspAddr === expAddr, req, "rspAddr", rspAddr, expAddr);
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = data;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic translate(input string req, input logic [31:0] addr,
                           input bit expHit, input logic [31:0] expAddr);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr;
    @(posedge clk); #1;
    reqValid = 1'b0;
    expectRsp(req, expHit, expAddr);
  endtask

  // Window w start at sel {w,0}, size at sel {w,1} (R8 encoding).
  task automatic setWin(input int w, input logic [31:0] st, input logic [31:0] sz);
    cfgWrite({w[1:0], 1'b0}, st);
    cfgWrite({w[1:0], 1'b1}, sz);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(rspValid === 1'b0 && rspHit === 1'b0 && rspMiss === 1'b0, "R1", "reset outputs",
          {29'b0, rspValid, rspHit, rspMiss}, 32'h0);
    translate("R1", 32'h0, 1'b0, 32'h0);
    translate("R5", 32'h1234, 1'b0, 32'h0);
  endtask

  task automatic testStacked();
    setWin(0, 32'h1000_0000, 32'h100);
    setWin(1, 32'h2000_0000, 32'h40);
    setWin(2, 32'h3000_0000, 32'h200);
    setWin(3, 32'h4000_0000, 32'h10);
    translate("R3", 32'h0,   1'b1, 32'h1000_0000);
    translate("R3", 32'hFF,  1'b1, 32'h1000_00FF);
    translate("R4", 32'h100, 1'b1, 32'h2000_0000);
    translate("R4", 32'h13F, 1'b1, 32'h2000_003F);
    translate("R4", 32'h140, 1'b1, 32'h3000_0000);
    translate("R4", 32'h33F, 1'b1, 32'h3000_01FF);
    translate("R4", 32'h340, 1'b1, 32'h4000_0000);
    translate("R4", 32'h34F, 1'b1, 32'h4000_000F);
    translate("R5", 32'h350, 1'b0, 32'h0);
    translate("R5", 32'hFFFF_FFFF, 1'b0, 32'h0);
  endtask

  task automatic testZeroSize();
    cfgWrite(3'b011, 32'h0);  // window 1 size -> 0
    translate("R6", 32'h100, 1'b1, 32'h3000_0000);
    translate("R10", 32'h30F, 1'b1, 32'h4000_000F);
    translate("R5", 32'h310, 1'b0, 32'h0);
  endtask

  task automatic testSelect();
    cfgWrite(3'b100, 32'h3500_0000);  // window 2 start only
    translate("R8", 32'h100, 1'b1, 32'h3500_0000);
    translate("R8", 32'h30F, 1'b1, 32'h4000_000F);
    translate("R8", 32'h0FF, 1'b1, 32'h1000_00FF);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 3'b001; cfgData = 32'h80;
    reqValid = 1'b1; reqAddr = 32'h90;
    @(posedge clk); #1;
    cfgWrEn = 1'b0; reqValid = 1'b0;
    expectRsp("R7", 1'b1, 32'h1000_0090);
    translate("R7", 32'h90, 1'b1, 32'h3500_0010);
  endtask

  task automatic testLatency();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h10;
    @(posedge clk); #1;
    expectRsp("R2", 1'b1, 32'h1000_0010);
    reqAddr = 32'h5000;
    @(posedge clk); #1;
    reqValid = 1'b0;
    expectRsp("R2", 1'b0, 32'h0);
    @(posedge clk); #1;
    check(rspValid === 1'b0, "R2", "no result without request", {31'b0, rspValid}, 32'h0);
    check(!rspHit && !rspMiss && rspAddr === 32'h0, "R9", "idle outputs quiet",
          rspAddr, 32'h0);
  endtask

  task automatic testWideSpan();
    setWin(0, 32'h0100_0000, 32'h8000_0000);
    setWin(1, 32'h0900_0000, 32'h8000_0000);
    cfgWrite(3'b101, 32'h0);
    cfgWrite(3'b111, 32'h0);
    translate("R4", 32'h7FFF_FFFF, 1'b1, 32'h80FF_FFFF);
    translate("R4", 32'h8000_0000, 1'b1, 32'h0900_0000);
    translate("R4", 32'hFFFF_FFFF, 1'b1, 32'h88FF_FFFF);
  endtask

  task automatic testAllZero();
    for (int w = 0; w < 4; w++) cfgWrite({w[1:0], 1'b1}, 32'h0);
    translate("R5", 32'h0, 1'b0, 32'h0);
    translate("R5", 32'h10, 1'b0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; cfgWrEn = 1'b0; cfgSel = '0; cfgData = '0;
    reqValid = 1'b0; reqAddr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testStacked();
    testZeroSize();
    testSelect();
    testSameCycle();
    testLatency();
    testWideSpan();
    testAllZero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule